// File: doc/BRIEF.md
# Transmit Frame Word Packer

This block takes an outgoing network frame as a stream of bytes and turns it into writes to a data port. The frame arrives in one or more segments of any length, including empty ones. The port is 8 or 16 bits wide, and a mode input chooses which. In 16-bit mode, bytes are paired into words. A byte left unpaired at the end of a segment is kept and joined to the first byte of the next segment.

Frames with fewer than 60 data bytes (the 64-byte minimum less the 4-byte checksum, which is added later in the path) are filled out with zeros to exactly 60 bytes. In 16-bit mode, a final unpaired byte is written with a zero upper half before any padding. When the last write of a frame has been accepted, the block reports the frame length on a one-cycle strobe.

The input uses a valid/ready handshake. Each beat carries a byte, or a marker with no byte, plus end-of-segment and end-of-frame flags. The output is a valid/ready write port with a single register stage.

Top module: `tx_word_packer`

## Requirements
- R1: After reset, out_valid and len_valid are 0, and in_ready is 1 while out_ready is 1.
- R2: In byte mode (mode input 0), each data byte is written unchanged and in order as one write: out_wide=0, the byte in out_data[7:0] and out_data[15:8]=0.
- R3: In word mode (mode input 1), two consecutive data bytes form one write with out_wide=1. The earlier byte is in out_data[7:0] and the later one in out_data[15:8].
- R4: In word mode, a segment that ends on an unpaired byte keeps that byte, and it is paired with the first data byte of the following segment.
- R5: A beat with in_nodata=1 carries no byte and leaves the packing state and the byte count unchanged. Such a beat must have in_seg_last=1, so an empty segment is one such beat.
- R6: A frame with fewer than MIN_LEN (60) data bytes is followed by zero writes until exactly 60 bytes have been written. In byte mode each pad write is one zero byte.
- R7: In word mode, a byte still held at frame end is written with out_data[15:8]=0. Any padding after it is whole zero words (out_wide=1).
- R8: A frame of 60 or more data bytes gets no padding writes.
- R9: len_valid is high for exactly one cycle, in the cycle after the frame's last write is accepted. len_out is then max(data bytes, 60), and no write is pending.
- R10: in_ready is 0 whenever out_ready is 0.
- R11: While out_valid=1 and out_ready=0, out_data and out_wide hold their values.
- R12: The mode input is sampled on the first accepted beat of a frame. Changes to it later in the same frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_mode | input | 1 | 1 = 16-bit port writes, 0 = 8-bit writes; sampled at frame start |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | DW (8) | Frame byte |
| in_nodata | input | 1 | Beat carries no byte (empty segment marker) |
| in_seg_last | input | 1 | Last beat of a segment |
| in_frame_last | input | 1 | Last beat of the frame |
| out_valid | output | 1 | Port write pending |
| out_ready | input | 1 | Port accepts the pending write |
| out_data | output | 2*DW (16) | Write data; upper half zero for byte writes |
| out_wide | output | 1 | 1 = 16-bit write, 0 = 8-bit write |
| len_valid | output | 1 | One-cycle strobe carrying the final frame length |
| len_out | output | LEN_W (16) | Written frame length |

## Verification
A byte that completes a write is seen on out_data in the cycle right after the edge that accepts it, because a single output register lies between input and port. A held byte adds no write until its partner arrives. Pad and flush writes follow at one per free output slot. The length strobe comes one cycle after the edge that hands off the last write. The bench drives all inputs at the falling edge, lets them settle, and records handshakes and the strobe at that same point. The expected write sequence and length come from a model of the requirements and are compared in order, so each result is checked in the cycle it becomes due, whatever the random ready pattern.

// File: rtl/twp_pkg.sv
package twp_pkg;
  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_TAIL   = 2'd1,
    ST_REPORT = 2'd2
  } twp_state_e;
endpackage

// File: rtl/twp_hold.sv
// Pairing register: keeps one unpaired byte in word mode and forms port words.
module twp_hold #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            take,
  input  logic            word_mode,
  input  logic [DW-1:0]   byte_in,
  input  logic            flush,
  output logic            emit,
  output logic [2*DW-1:0] emit_data,
  output logic            emit_wide,
  output logic            held_v
);
  logic [DW-1:0] held_q;

  always_comb begin
    emit      = 1'b0;
    emit_data = '0;
    emit_wide = 1'b0;
    if (take) begin
      if (!word_mode) begin
        emit      = 1'b1;
        emit_data = {{DW{1'b0}}, byte_in};
      end else if (held_v) begin
        emit      = 1'b1;
        emit_data = {byte_in, held_q};
        emit_wide = 1'b1;
      end
    end else if (flush && held_v) begin
      emit      = 1'b1;
      emit_data = {{DW{1'b0}}, held_q};
      emit_wide = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      held_v <= 1'b0;
    end else if (take && word_mode) begin
      held_v <= !held_v;
    end else if (flush) begin
      held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take && word_mode && !held_v) held_q <= byte_in;
  end

  // R4: a held byte survives idle cycles and segment boundaries untouched
  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    held_v && !take && !flush && !clear |=> held_v && $stable(held_q));

  // R7: end-of-frame flush never coincides with a new byte
  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(take && flush));
endmodule

// File: rtl/twp_count.sv
// Byte counters: data bytes received and bytes covered by issued writes.
module twp_count #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             data_inc,
  input  logic             wr_inc,
  input  logic             wr_two,
  output logic [LEN_W-1:0] data_len,
  output logic [LEN_W-1:0] cover_len,
  output logic             pad_due,
  output logic [LEN_W-1:0] final_len
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data_len  <= '0;
      cover_len <= '0;
    end else begin
      if (data_inc) data_len <= data_len + LEN_W'(1);
      if (wr_inc)   cover_len <= cover_len + (wr_two ? LEN_W'(2) : LEN_W'(1));
    end
  end

  assign pad_due   = cover_len < MIN_L;
  assign final_len = (data_len < MIN_L) ? MIN_L : data_len;

  // R8: writes never run more than one byte past the data or the minimum
  p_cover_r8: assert property (@(posedge clk) disable iff (rst)
    cover_len <= final_len + LEN_W'(1));
endmodule

// File: rtl/tx_word_packer.sv
module tx_word_packer
  import twp_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_nodata,
  input  logic             in_seg_last,
  input  logic             in_frame_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*DW-1:0]  out_data,
  output logic             out_wide,
  output logic             len_valid,
  output logic [LEN_W-1:0] len_out
);
  localparam int PW = 2 * DW;

  twp_state_e      st;
  logic            fresh;
  logic            mode_q;
  logic            eff_mode;
  logic            accept, take, slot_free;
  logic            flush, pad_go, tail_done, clear;
  logic            held_v, h_emit, h_wide;
  logic [PW-1:0]   h_data;
  logic            load, ld_wide;
  logic [PW-1:0]   ld_data;
  logic [LEN_W-1:0] data_len, cover_len, final_len;
  logic            pad_due;

  assign eff_mode  = fresh ? word_mode : mode_q;
  assign in_ready  = (st == ST_DATA) && out_ready;
  assign accept    = in_valid && in_ready;
  assign take      = accept && !in_nodata;
  assign slot_free = !out_valid || out_ready;
  assign clear     = (st == ST_REPORT);
  assign flush     = (st == ST_TAIL) && slot_free && held_v;
  assign pad_go    = (st == ST_TAIL) && slot_free && !held_v && pad_due;
  assign tail_done = (st == ST_TAIL) && slot_free && !held_v && !pad_due;

  twp_hold #(.DW(DW)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .take      (take),
    .word_mode (eff_mode),
    .byte_in   (in_data),
    .flush     (flush),
    .emit      (h_emit),
    .emit_data (h_data),
    .emit_wide (h_wide),
    .held_v    (held_v)
  );

  assign load    = h_emit || pad_go;
  assign ld_data = pad_go ? '0 : h_data;
  assign ld_wide = pad_go ? mode_q : h_wide;

  twp_count #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_count (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .data_inc  (take),
    .wr_inc    (load),
    .wr_two    (ld_wide),
    .data_len  (data_len),
    .cover_len (cover_len),
    .pad_due   (pad_due),
    .final_len (final_len)
  );

  // frame sequencing and mode capture
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_DATA;
      fresh  <= 1'b1;
      mode_q <= 1'b0;
    end else begin
      if (accept && fresh) begin
        fresh  <= 1'b0;
        mode_q <= word_mode;
      end
      case (st)
        ST_DATA:   if (accept && in_frame_last) st <= ST_TAIL;
        ST_TAIL:   if (tail_done) st <= ST_REPORT;
        default: begin
          st    <= ST_DATA;
          fresh <= 1'b1;
        end
      endcase
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_wide  <= 1'b0;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_data <= ld_data;
        out_wide <= ld_wide;
      end
    end
  end

  // length report
  always_ff @(posedge clk) begin
    if (rst) begin
      len_valid <= 1'b0;
      len_out   <= '0;
    end else begin
      len_valid <= tail_done;
      if (tail_done) len_out <= final_len;
    end
  end

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    !out_ready |-> !in_ready);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_wide));

  p_len_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> !out_valid);

  p_len_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    len_valid |=> !len_valid);

  p_len_min_r6: assert property (@(posedge clk) disable iff (rst)
    len_valid |-> len_out >= LEN_W'(MIN_LEN));

  p_upper_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_wide |-> out_data[PW-1:DW] == '0);

  p_pad_even_r7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TAIL) && mode_q |-> cover_len[0] == 1'b0);

  p_marker_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_nodata |-> in_seg_last);

  p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !fresh && (st != ST_REPORT) |=> $stable(mode_q));
endmodule

// File: tb/sim_tx_word_packer.sv
module sim_tx_word_packer;
  logic        clk = 1'b0;
  logic        rst;
  logic        word_mode, in_valid, in_nodata, in_seg_last, in_frame_last;
  logic [7:0]  in_data;
  logic        in_ready, out_valid, out_ready, out_wide, len_valid;
  logic [15:0] out_data, len_out;

  int total = 0;
  int bad = 0;
  bit fin = 0;

  int         seg_len[$];
  logic [7:0] dq[$];
  logic [7:0] bd[$];
  bit         bnd[$], bsl[$], bfl[$];
  logic [16:0] exp_w[$];
  int         exp_len;

  always #4 clk = ~clk;

  tx_word_packer u0 (
    .clk(clk), .rst(rst), .word_mode(word_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_nodata(in_nodata), .in_seg_last(in_seg_last), .in_frame_last(in_frame_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_wide(out_wide), .len_valid(len_valid), .len_out(len_out)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // expected writes {wide, data} and length from the requirements
  task automatic build_exp(input bit m);
    int n = dq.size();
    int c = 0;
    exp_w.delete();
    if (!m) begin
      foreach (dq[i]) exp_w.push_back({1'b0, 8'h00, dq[i]});
      for (int k = n; k < 60; k++) exp_w.push_back(17'h0);
    end else begin
      while (c + 1 < n) begin
        exp_w.push_back({1'b1, dq[c+1], dq[c]});
        c += 2;
      end
      if (c < n) begin
        exp_w.push_back({1'b1, 8'h00, dq[c]});
        c += 2;
      end
      while (c < 60) begin
        exp_w.push_back({1'b1, 16'h0});
        c += 2;
      end
    end
    exp_len = (n < 60) ? 60 : n;
  endtask

  task automatic run_frame(input bit m, input int rdy_pct, input bit toggle,
                           input string tag);
    int  bi = 0, wi = 0;
    bit  started = 0, got_len = 0, r10_bad = 0;
    dq.delete(); bd.delete(); bnd.delete(); bsl.delete(); bfl.delete();
    foreach (seg_len[s]) begin
      if (seg_len[s] == 0) begin
        bd.push_back(8'h00); bnd.push_back(1); bsl.push_back(1); bfl.push_back(0);
      end else begin
        for (int j = 0; j < seg_len[s]; j++) begin
          logic [7:0] b = 8'($urandom);
          dq.push_back(b);
          bd.push_back(b); bnd.push_back(0);
          bsl.push_back(j == seg_len[s] - 1); bfl.push_back(0);
        end
      end
    end
    bfl[bfl.size()-1] = 1;
    build_exp(m);
    while (!got_len) begin
      @(negedge clk);
      out_ready = (($urandom % 100) < rdy_pct);
      word_mode = (started && toggle) ? 1'($urandom) : m;
      if (bi < bd.size() && ($urandom % 4) != 0) begin
        in_valid = 1; in_data = bd[bi]; in_nodata = bnd[bi];
        in_seg_last = bsl[bi]; in_frame_last = bfl[bi];
      end else begin
        in_valid = 0; in_data = 8'h00; in_nodata = 0;
        in_seg_last = 0; in_frame_last = 0;
      end
      #1;
      if (in_ready && !out_ready) r10_bad = 1;
      if (out_valid && out_ready) begin
        if (wi < exp_w.size())
          chk({out_wide, out_data} == exp_w[wi], tag, "write", {out_wide, out_data}, exp_w[wi]);
        else
          chk(0, tag, "extra write", {out_wide, out_data}, 0);
        wi++;
      end
      if (len_valid) begin
        chk(len_out == 16'(exp_len), "R9", "length", len_out, exp_len);
        chk(wi == exp_w.size(), "R9", "write count at strobe", wi, exp_w.size());
        got_len = 1;
      end
      if (in_valid && in_ready) begin
        bi++;
        started = 1;
      end
    end
    chk(bi == bd.size(), "R5", "beats consumed", bi, bd.size());
    chk(!r10_bad, "R10", "in_ready while out_ready low", r10_bad, 0);
    @(negedge clk);
    in_valid = 0;
    #1;
    chk(!len_valid, "R9", "strobe one cycle", len_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; word_mode = 0; in_valid = 0; in_data = 0; in_nodata = 0;
    in_seg_last = 0; in_frame_last = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(!len_valid, "R1", "len_valid after reset", len_valid, 0);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);

    // R2 R6: short byte-mode frame
    seg_len = '{10};            run_frame(0, 100, 0, "R2/R6");
    // R3 R4 R5 R7: odd bytes across segments with an empty segment
    seg_len = '{3, 0, 4};       run_frame(1, 70, 0, "R4/R5/R7");
    // R8 R7: long odd word-mode frame
    seg_len = '{5, 5, 0, 51};   run_frame(1, 60, 0, "R8/R7");
    // R8: long byte-mode frame, no padding
    seg_len = '{64};            run_frame(0, 80, 0, "R8");
    // R3 R4: exactly 60, odd split
    seg_len = '{59, 1};         run_frame(1, 100, 0, "R3/R4");
    // R5 R6: empty frame, word mode
    seg_len = '{0};             run_frame(1, 90, 0, "R5/R6");
    // R12: mode toggled after the first beat
    seg_len = '{7, 9};          run_frame(1, 75, 1, "R12");
    seg_len = '{13};            run_frame(0, 75, 1, "R12");
    // R10 R11: heavy back-pressure
    seg_len = '{21, 2};         run_frame(1, 20, 0, "R11");

    for (int f = 0; f < 40; f++) begin
      int ns = 1 + ($urandom % 4);
      seg_len.delete();
      for (int s = 0; s < ns; s++)
        seg_len.push_back(($urandom % 5 == 0) ? 0 : int'($urandom % 31));
      if ($urandom % 4 == 0) seg_len.push_back(40 + int'($urandom % 40));
      run_frame(1'($urandom), 40 + int'($urandom % 61), 1'($urandom), "R2/R3/R4");
    end

    fin = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule